// File: doc/BRIEF.md
# Bus Cycle Watchdog and System Control Register

This block pairs an 8-bit system control and status register with a watchdog on the processor bus. While a bus cycle is open and no acknowledge has come back, a counter runs. If the count reaches the configured limit (128 clocks by default) and the timer is enabled, the block ends the cycle with a one-clock bus-error pulse. It also records the cause in a sticky status bit. An address decoder feeds in write-protect and privilege violation strobes. Each strobe sets its own status bit. It ends the open cycle with a bus error only when the timer is enabled. With the timer disabled, the offending cycle is left for the rest of the system to handle.

Software reaches the register through a one-clock select strobe with a write qualifier and a supervisor qualifier. Status bits are cleared by writing 1 to them. When the supervisor-only control bit is set, user-mode accesses are refused. A refused access reads as zero, leaves the register untouched and raises an access-error pulse. The register also holds control bits for functions outside this block: a memory-map select and a watchdog-hold bit. These bits are stored and read back only.

Top module: `bus_guard_ctrl`

## Requirements
- R1: After reset the register reads 0x0C, and bus_err and acc_err are 0.
- R2: Field positions are: bit 7 timeout status, bit 6 write-protect status, bit 5 privilege status, bit 4 timer enable, bit 3 supervisor-only, bit 2 map select, bit 1 reserved, bit 0 watchdog hold. The reserved bit always reads 0, and writes to it are ignored.
- R3: With the timer enabled, if cyc_active stays high with no cyc_ack for 128 rising edges after the edge that sampled cyc_start, bus_err is high for exactly the clock after the 128th edge, and bit 7 becomes 1.
- R4: A cyc_ack or a new cyc_start sampled during an open cycle restarts the count, so a full 128 further edges are needed before a timeout.
- R5: With the timer enable at 0, no bus_err is ever produced and bit 7 is never set.
- R6: A wp_viol strobe sets bit 6, and a priv_viol strobe sets bit 5, whatever the enable. If the enable is 1 during an active cycle, the strobe also produces bus_err on the next clock and sets bit 7.
- R7: bus_err fires at most once per bus cycle. After it fires, further timeouts and violations in the same cycle produce no pulse until a new cycle begins.
- R8: Writing 1 to a status bit (bits 7..5) clears it. Writing 0 leaves it unchanged.
- R9: When a hardware set and a write-1-to-clear reach the same status bit in the same clock, the bit ends up set.
- R10: When bit 3 is 1, an access with reg_sup at 0 leaves the register unchanged and reads 0. acc_err is then high for exactly the next clock.
- R11: A permitted read drives the register value on reg_rdata in the same clock as the select. At all other times reg_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register access strobe, one clock per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sup | input | 1 | 1 = supervisor access, 0 = user data access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the select clock |
| acc_err | output | 1 | One-clock pulse after a refused access |
| cyc_start | input | 1 | First clock of a new bus cycle |
| cyc_active | input | 1 | High while a bus cycle is open |
| cyc_ack | input | 1 | Data-transfer acknowledge |
| wp_viol | input | 1 | Write-protect violation strobe from the decoder |
| priv_viol | input | 1 | Privilege violation strobe from the decoder |
| bus_err | output | 1 | One-clock bus-error pulse ending a faulting cycle |

## Verification
The bench counts edges exactly around the timeout. It looks for the pulse on the clock after the 128th edge, and for silence on every clock before it. A counter that is off by one would fire a clock early or late. A counter that ignores an acknowledge or a restart would fire inside the second window. The bench keeps a faulted cycle open for long stretches and sends further violations into it. A design without a one-shot latch would pulse again. Other tests cover a violation with the timer disabled, a clear that collides with a set in the same clock, and user accesses against the supervisor-only bit. A wrong enable gate, a clear that takes priority, or a leaky protection path would each change a value the bench reads back.

// File: rtl/bus_guard_pkg.sv
package bus_guard_pkg;

  localparam int REG_W = 8;

  // field positions (software decodes these)
  localparam int BIT_TMO  = 7;
  localparam int BIT_WPV  = 6;
  localparam int BIT_PRV  = 5;
  localparam int BIT_TEN  = 4;
  localparam int BIT_SUP  = 3;
  localparam int BIT_MAP  = 2;
  localparam int BIT_RSV  = 1;
  localparam int BIT_HOLD = 0;

  localparam logic [REG_W-1:0] REG_RESET = 8'h0C;
  localparam logic [REG_W-1:0] STAT_MASK = (REG_W'(1) << BIT_TMO) |
                                           (REG_W'(1) << BIT_WPV) |
                                           (REG_W'(1) << BIT_PRV);
  localparam logic [REG_W-1:0] CTRL_MASK = (REG_W'(1) << BIT_TEN) |
                                           (REG_W'(1) << BIT_SUP) |
                                           (REG_W'(1) << BIT_MAP) |
                                           (REG_W'(1) << BIT_HOLD);

  typedef struct packed {
    logic tmo;
    logic wpv;
    logic prv;
  } fault_set_t;

endpackage

// File: rtl/bg_rst_sync.sv
module bg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/bg_cycle_timer.sv
module bg_cycle_timer #(
  parameter int TMO_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_en,
  input  logic cyc_start,
  input  logic cyc_active,
  input  logic cyc_ack,
  input  logic wp_viol,
  input  logic priv_viol,
  output logic fault_evt,
  output logic bus_err
);

  localparam int CW = $clog2(TMO_CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fired_q, fired_d;
  logic          fired_eff;
  logic          counting;
  logic          tmo_hit;
  logic          cnt_en;
  logic          berr_d;

  // a new cycle frees the one-shot for that same clock
  assign fired_eff = fired_q & ~cyc_start;
  assign counting  = cyc_active & ~cyc_start & ~cyc_ack & tmr_en & ~fired_eff;
  assign tmo_hit   = counting & (cnt_q == CNT_LAST);
  assign fault_evt = tmr_en & cyc_active & ~fired_eff &
                     (tmo_hit | wp_viol | priv_viol);

  always_comb begin
    cnt_d = cnt_q;
    if (cyc_start | cyc_ack | ~cyc_active) cnt_d = '0;
    else if (counting & ~tmo_hit)          cnt_d = cnt_q + 1'b1;
    cnt_en = (cnt_d != cnt_q);
  end

  always_comb begin
    fired_d = fired_q;
    if (fault_evt)                     fired_d = 1'b1;
    else if (cyc_start | ~cyc_active)  fired_d = 1'b0;
    berr_d = fault_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
      bus_err <= 1'b0;
    end else begin
      fired_q <= fired_d;
      bus_err <= berr_d;
    end
  end

endmodule

// File: rtl/bg_ctrl_status.sv
module bg_ctrl_status
  import bus_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ok,
  input  logic [REG_W-1:0] wdata,
  input  fault_set_t       set_i,
  output logic [REG_W-1:0] reg_q
);

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] reg_d;
  logic             reg_en;

  always_comb begin
    set_vec          = '0;
    set_vec[BIT_TMO] = set_i.tmo;
    set_vec[BIT_WPV] = set_i.wpv;
    set_vec[BIT_PRV] = set_i.prv;
  end

  always_comb begin
    reg_d = '0;
    for (int b = 0; b < REG_W; b++) begin
      if (STAT_MASK[b])      reg_d[b] = set_vec[b] | (reg_q[b] & ~(wr_ok & wdata[b]));
      else if (CTRL_MASK[b]) reg_d[b] = wr_ok ? wdata[b] : reg_q[b];
      else                   reg_d[b] = 1'b0;
    end
    reg_en = wr_ok | (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_q <= REG_RESET;
    else if (reg_en) reg_q <= reg_d;
  end

endmodule

// File: rtl/bg_host_port.sv
module bg_host_port
  import bus_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic             reg_sup,
  input  logic [REG_W-1:0] reg_q,
  output logic             wr_ok,
  output logic [REG_W-1:0] reg_rdata,
  output logic             acc_err
);

  logic allowed;
  logic refused;
  logic acc_err_d;

  assign allowed   = reg_sup | ~reg_q[BIT_SUP];
  assign refused   = reg_sel & ~allowed;
  assign wr_ok     = reg_sel & reg_wr & allowed;
  assign reg_rdata = (reg_sel & ~reg_wr & allowed) ? reg_q : '0;

  always_comb acc_err_d = refused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_err <= 1'b0;
    else        acc_err <= acc_err_d;
  end

endmodule

// File: rtl/bus_guard_ctrl.sv
module bus_guard_ctrl
  import bus_guard_pkg::*;
#(
  parameter int TMO_CYCLES = 128,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic             reg_sup,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             acc_err,
  input  logic             cyc_start,
  input  logic             cyc_active,
  input  logic             cyc_ack,
  input  logic             wp_viol,
  input  logic             priv_viol,
  output logic             bus_err
);

  logic             rst_sync_n;
  logic             wr_ok;
  logic             fault_evt;
  logic [REG_W-1:0] reg_q;
  fault_set_t       set_s;

  bg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  bg_cycle_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tmr_en     (reg_q[BIT_TEN]),
    .cyc_start  (cyc_start),
    .cyc_active (cyc_active),
    .cyc_ack    (cyc_ack),
    .wp_viol    (wp_viol),
    .priv_viol  (priv_viol),
    .fault_evt  (fault_evt),
    .bus_err    (bus_err)
  );

  always_comb begin
    set_s.tmo = fault_evt;
    set_s.wpv = wp_viol;
    set_s.prv = priv_viol;
  end

  bg_ctrl_status u_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_ok (wr_ok),
    .wdata (reg_wdata),
    .set_i (set_s),
    .reg_q (reg_q)
  );

  bg_host_port u_port (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_sup   (reg_sup),
    .reg_q     (reg_q),
    .wr_ok     (wr_ok),
    .reg_rdata (reg_rdata),
    .acc_err   (acc_err)
  );

endmodule

module bus_guard_chk
  import bus_guard_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel,
  input logic             reg_wr,
  input logic             reg_sup,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic [REG_W-1:0] reg_q,
  input logic             acc_err,
  input logic             cyc_start,
  input logic             bus_err
);

  logic user_refused;
  assign user_refused = reg_sel & ~reg_sup & reg_q[BIT_SUP];

  AST_BERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !cyc_start) |=> !bus_err); // R7
  AST_BERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(reg_q[BIT_TEN])); // R5
  AST_BERR_SETS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> reg_q[BIT_TMO]); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_q[BIT_RSV] && !reg_rdata[BIT_RSV]); // R2
  AST_USER_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    user_refused |-> (reg_rdata == '0)); // R10
  AST_USER_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    user_refused |=> acc_err); // R10
  AST_USER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    user_refused |=> $stable(reg_q[BIT_TEN:0])); // R10
  AST_ACC_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(user_refused)); // R10
  AST_W0_KEEPS_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_q[BIT_TMO] && !reg_wdata[BIT_TMO]) |=> reg_q[BIT_TMO]); // R8

endmodule

bind bus_guard_ctrl bus_guard_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_sup   (reg_sup),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .reg_q     (reg_q),
  .acc_err   (acc_err),
  .cyc_start (cyc_start),
  .bus_err   (bus_err)
);

// File: tb/bus_guard_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_guard_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0, reg_wr = 1'b0, reg_sup = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       acc_err;
  logic       cyc_start = 1'b0, cyc_active = 1'b0, cyc_ack = 1'b0;
  logic       wp_viol = 1'b0, priv_viol = 1'b0;
  logic       bus_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  bus_guard_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_sup(reg_sup),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_err(acc_err),
    .cyc_start(cyc_start), .cyc_active(cyc_active), .cyc_ack(cyc_ack),
    .wp_viol(wp_viol), .priv_viol(priv_viol), .bus_err(bus_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] d, logic sup);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_sup = sup; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic sup, output logic [7:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_sup = sup;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  // a restart mark (start or ack) was driven at the current negedge
  task automatic window_after_mark(string req);
    bit early = 1'b0;
    @(negedge clk);
    cyc_start = 1'b0; cyc_ack = 1'b0;
    if (bus_err) early = 1'b1;
    repeat (127) begin
      @(negedge clk);
      if (bus_err) early = 1'b1;
    end
    chk({req, " no bus_err before 128th edge"}, early, 0);
    @(negedge clk);
    chk({req, " bus_err after 128th edge"}, bus_err, 1);
    @(negedge clk);
    chk({req, " bus_err single clock"}, bus_err, 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 bus_err at reset", bus_err, 0);
    chk("R1 acc_err at reset", acc_err, 0);
    reg_read(1'b1, d);
    chk("R1 reset value", d, 8'h0C);
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    bit again = 1'b0;
    reg_write(8'h1C, 1'b1);
    @(negedge clk);
    cyc_active = 1'b1; cyc_start = 1'b1;
    window_after_mark("R3");
    repeat (200) begin
      @(negedge clk);
      if (bus_err) again = 1'b1;
    end
    chk("R7 no second timeout in faulted cycle", again, 0);
    wp_viol = 1'b1;
    @(negedge clk);
    wp_viol = 1'b0;
    @(negedge clk);
    chk("R7 violation after fault gives no pulse", bus_err, 0);
    cyc_active = 1'b0;
    reg_read(1'b1, d);
    chk("R3 timeout status set", d, 8'hDC);
    reg_write(8'h40, 1'b1);  // clear wp status, disable timer
    reg_write(8'h1C, 1'b1);  // restore enable, bits 7..5 written 0
    reg_read(1'b1, d);
    chk("R8 writing 0 keeps status", d, 8'h9C);
    reg_write(8'h9C, 1'b1);
    reg_read(1'b1, d);
    chk("R8 writing 1 clears status", d, 8'h1C);
  endtask

  task automatic t_restart();
    logic [7:0] d;
    @(negedge clk);
    cyc_active = 1'b1; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    repeat (100) @(negedge clk);
    cyc_start = 1'b1;
    window_after_mark("R4 restart by new start");
    cyc_active = 1'b0;
    @(negedge clk);
    cyc_active = 1'b1; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    repeat (120) @(negedge clk);
    cyc_ack = 1'b1;
    window_after_mark("R4 restart by ack");
    cyc_active = 1'b0;
    reg_write(8'h9C, 1'b1);
    reg_read(1'b1, d);
    chk("R4 status cleared", d, 8'h1C);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    bit seen = 1'b0;
    reg_write(8'h0C, 1'b1);
    @(negedge clk);
    cyc_active = 1'b1; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (bus_err) seen = 1'b1;
    end
    chk("R5 no bus_err with timer off", seen, 0);
    cyc_active = 1'b0;
    reg_read(1'b1, d);
    chk("R5 timeout status stays 0", d, 8'h0C);
  endtask

  task automatic t_viol_en();
    logic [7:0] d;
    reg_write(8'h1C, 1'b1);
    @(negedge clk);
    cyc_active = 1'b1; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; wp_viol = 1'b1;
    @(negedge clk);
    wp_viol = 1'b0;
    chk("R6 write-protect violation bus_err", bus_err, 1);
    @(negedge clk);
    chk("R6 bus_err one clock", bus_err, 0);
    priv_viol = 1'b1;
    @(negedge clk);
    priv_viol = 1'b0;
    chk("R7 second violation same cycle no pulse", bus_err, 0);
    cyc_active = 1'b0;
    reg_read(1'b1, d);
    chk("R6 all causes recorded", d, 8'hFC);
    reg_write(8'hFC, 1'b1);
    reg_read(1'b1, d);
    chk("R8 clear all status", d, 8'h1C);
  endtask

  task automatic t_viol_dis();
    logic [7:0] d;
    reg_write(8'h0C, 1'b1);
    @(negedge clk);
    cyc_active = 1'b1; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; priv_viol = 1'b1;
    @(negedge clk);
    priv_viol = 1'b0;
    chk("R6 no bus_err with timer off", bus_err, 0);
    cyc_active = 1'b0;
    reg_read(1'b1, d);
    chk("R6 privilege status set with timer off", d, 8'h2C);
    reg_write(8'h2C, 1'b1);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    reg_write(8'h1C, 1'b1);
    @(negedge clk);
    cyc_active = 1'b1; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; wp_viol = 1'b1;
    reg_sel = 1'b1; reg_wr = 1'b1; reg_sup = 1'b1; reg_wdata = 8'h5C;
    @(negedge clk);
    wp_viol = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
    chk("R6 bus_err on collision clock", bus_err, 1);
    cyc_active = 1'b0;
    reg_read(1'b1, d);
    chk("R9 set beats clear", d, 8'hDC);
    reg_write(8'hDC, 1'b1);
  endtask

  task automatic t_fields();
    logic [7:0] d;
    reg_write(8'h0F, 1'b1);
    reg_read(1'b1, d);
    chk("R2 reserved bit reads 0, hold bit kept", d, 8'h0D);
    reg_write(8'h07, 1'b1);
    reg_read(1'b1, d);
    chk("R2 supervisor-only bit 3 cleared, map bit 2 kept", d, 8'h05);
    reg_write(8'h0D, 1'b1);
  endtask

  task automatic t_user();
    logic [7:0] d;
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_sup = 1'b0; reg_wdata = 8'h00;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
    chk("R10 acc_err after refused write", acc_err, 1);
    @(negedge clk);
    chk("R10 acc_err one clock", acc_err, 0);
    reg_read(1'b0, d);
    chk("R10 refused read returns 0", d, 8'h00);
    reg_read(1'b1, d);
    chk("R10 register unchanged by user write", d, 8'h0D);
    reg_write(8'h05, 1'b1);
    reg_read(1'b0, d);
    chk("R11 user read allowed when bit 3 clear", d, 8'h05);
    reg_write(8'h01, 1'b0);
    chk("R10 no acc_err on allowed user write", acc_err, 0);
    reg_read(1'b1, d);
    chk("R11 user write took effect", d, 8'h01);
    @(negedge clk);
    #1 chk("R11 rdata 0 without select", reg_rdata, 8'h00);
    reg_write(8'h0C, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_timeout();
    t_restart();
    t_disabled();
    t_viol_en();
    t_viol_dis();
    t_set_wins();
    t_fields();
    t_user();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule